// File: doc/BRIEF.md
# Oversampled IR Sampler

This block takes one infrared receiver pin and samples it at a fixed programmable rate that is well above the remote-control bit rate. Around 4 kHz gives roughly two samples per bit-level cell. Each sample is shifted in from the top of a 32-bit word. When 32 samples have been taken, the word is copied into a holding register and a status bit is raised. The status bit can drive the interrupt output through a mask. Software reads the held word and recovers the bi-phase bits from the level transitions.

Sampling runs freely and has no framing. A word begins wherever the previous one ended, and nothing in a word lines up with the incoming signal. Software sets the divider first and then sets the enable bit. The pin passes through a synchroniser before the first sampling flop.

Register map (word addresses on `addr_i`):
- 0 CONTROL: bit 0 is the enable bit.
- 1 DIVIDER: bits 15:0 hold the reload value.
- 2 STATUS: bit 18 is word-ready and bit 19 is overrun. Both are write-1-to-clear.
- 3 MASK: all 32 bits are stored.
- 4 SAMPLE: the held word, read-only.

Reads of unmapped addresses return 0.

Top module: `ir_sampler_top`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is low.
- R2: With DIVIDER = d and the enable bit set, a sample is taken every d+1 clocks. The first sample is taken on the (d+1)th clock edge after the edge that writes the enable bit. When d = 0, a sample is taken every clock.
- R3: The level captured by a sample is the level of `ir_i` at the clock edge two edges before the sample edge (two-stage synchroniser).
- R4: Samples enter from the top. In a completed word, bit 31 holds the newest sample and bit 0 holds the oldest.
- R5: On every 32nd sample the word is copied into SAMPLE. SAMPLE then stays unchanged until the next word completes.
- R6: STATUS bit 18 is set when a word completes. Writing 1 to bit 18 clears it and writing 0 has no effect. If a clear and a completion fall on the same edge, the bit stays set.
- R7: If a word completes while STATUS bit 18 is still set, STATUS bit 19 is set. Bit 19 is cleared by writing 1 to it.
- R8: `irq_o` is high exactly when STATUS bit 18 and MASK bit 18 are both set, or when STATUS bit 19 and MASK bit 19 are both set.
- R9: While the enable bit is 0, no samples are taken, and SAMPLE and STATUS do not change. The partial sample count is discarded, so the first word after re-enabling holds 32 new samples.
- R10: Words follow each other with no gap. Sample 33 after enabling is the oldest bit of the second word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ir_i | input | 1 | IR receiver pin, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Masked interrupt |

## Verification
A divider that is off by one cycle moves every sample edge. Because the pin pattern is random, the captured word differs from the expected value at the first word boundary, after 32·(d+1) clocks. A bit counter that is off by one, a wrong shift direction or a wrong synchroniser depth also corrupts the word that appears in SAMPLE at that boundary. Status errors are checked on the edge where the word completes, one edge before it and half a word later. Errors in overrun, clear priority or masking show at the STATUS read and on `irq_o` right after the second completion or the clearing write.

// File: rtl/ir_sampler_pkg.sv
package ir_sampler_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned DONE_BIT = 18;
  localparam int unsigned OVR_BIT  = 19;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_DIV    = 3'd1,
    A_STAT   = 3'd2,
    A_MASK   = 3'd3,
    A_SAMPLE = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/ir_sync.sv
module ir_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  // idle IR receiver is marking (1)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ir_rate_div.sv
module ir_rate_div #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             strobe_o
);
  logic [DIV_W-1:0] cnt_q;

  assign strobe_o = en_i && (cnt_q == '0);

  // held at the reload value while disabled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!en_i || strobe_o)  cnt_q <= div_i;
    else                         cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/ir_shift_cap.sv
module ir_shift_cap #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              strobe_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] hold_o,
  output logic              done_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W);

  logic [WORD_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]  bcnt_q;

  assign shreg_d = {bit_i, shreg_q[WORD_W-1:1]};
  assign done_o  = strobe_i && (bcnt_q == CNT_W'(WORD_W-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      bcnt_q  <= '0;
    end else if (!en_i) begin
      shreg_q <= '0;
      bcnt_q  <= '0;
    end else if (strobe_i) begin
      shreg_q <= shreg_d;
      bcnt_q  <= done_o ? '0 : bcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hold_o <= '0;
    else if (done_o) hold_o <= shreg_d;
  end
endmodule

// File: rtl/ir_irq_stat.sv
module ir_irq_stat (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       done_i,
  input  logic [1:0] clr_i,   // {ovr, done} write-1-to-clear
  input  logic [1:0] mask_i,  // {ovr, done}
  output logic       done_o,
  output logic       ovr_o,
  output logic       irq_o
);
  // set wins over a same-edge clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      ovr_o  <= 1'b0;
    end else begin
      done_o <= done_i | (done_o & ~clr_i[0]);
      ovr_o  <= (done_i & done_o & ~clr_i[0]) | (ovr_o & ~clr_i[1]);
    end
  end

  assign irq_o = (done_o & mask_i[0]) | (ovr_o & mask_i[1]);
endmodule

// File: rtl/ir_sampler_top.sv
module ir_sampler_top
  import ir_sampler_pkg::*;
#(
  parameter int unsigned WORD_W      = 32,
  parameter int unsigned DIV_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ir_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              irq_o
);
  logic              en_q;
  logic [DIV_W-1:0]  div_q;
  logic [REG_W-1:0]  mask_q;
  logic              ir_s;
  logic              strobe;
  logic              word_done;
  logic [WORD_W-1:0] hold;
  logic              stat_done, stat_ovr;
  logic [1:0]        stat_clr;
  logic [REG_W-1:0]  stat_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      div_q  <= '0;
      mask_q <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        A_CTRL:  en_q   <= wdata_i[0];
        A_DIV:   div_q  <= wdata_i[DIV_W-1:0];
        A_MASK:  mask_q <= wdata_i;
        default: ;
      endcase
    end
  end

  assign stat_clr = (wr_en_i && addr_i == A_STAT) ?
                    {wdata_i[OVR_BIT], wdata_i[DONE_BIT]} : 2'b00;

  ir_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (ir_i), .q_o (ir_s)
  );

  ir_rate_div #(.DIV_W(DIV_W)) u_div (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (en_q), .div_i (div_q),
    .strobe_o (strobe)
  );

  ir_shift_cap #(.WORD_W(WORD_W)) u_cap (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (en_q), .strobe_i (strobe),
    .bit_i (ir_s), .hold_o (hold), .done_o (word_done)
  );

  ir_irq_stat u_stat (
    .clk_i (clk_i), .rst_ni (rst_ni), .done_i (word_done), .clr_i (stat_clr),
    .mask_i ({mask_q[OVR_BIT], mask_q[DONE_BIT]}),
    .done_o (stat_done), .ovr_o (stat_ovr), .irq_o (irq_o)
  );

  always_comb begin
    stat_word           = '0;
    stat_word[DONE_BIT] = stat_done;
    stat_word[OVR_BIT]  = stat_ovr;
  end

  always_comb begin
    case (addr_i)
      A_CTRL:   rdata_o = REG_W'(en_q);
      A_DIV:    rdata_o = REG_W'(div_q);
      A_STAT:   rdata_o = stat_word;
      A_MASK:   rdata_o = mask_q;
      A_SAMPLE: rdata_o = REG_W'(hold);
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ir_sampler_chk.sv
module ir_sampler_chk #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DIV_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_q,
  input logic [DIV_W-1:0]  div_q,
  input logic              strobe,
  input logic              word_done,
  input logic [WORD_W-1:0] hold,
  input logic              stat_done,
  input logic              stat_ovr
);
  // R2
  strobe_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe && div_q != '0) |=> !strobe);

  // R2
  first_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(en_q) && div_q != '0) |-> !strobe);

  // R5
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(hold) |-> $past(word_done));

  // R6
  done_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_done) |-> $past(word_done));

  // R7
  ovr_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_ovr) |-> ($past(word_done) && $past(stat_done)));
endmodule

bind ir_sampler_top ir_sampler_chk #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_q      (en_q),
  .div_q     (div_q),
  .strobe    (strobe),
  .word_done (word_done),
  .hold      (hold),
  .stat_done (stat_done),
  .stat_ovr  (stat_ovr)
);

// File: tb/tb_ir_sampler_top.sv
module tb_ir_sampler_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ir_i = 1'b1;
  logic        wr_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done_flag = 0;
  logic hist [0:4095];

  localparam logic [2:0] CTRL = 3'd0, DIV = 3'd1, STAT = 3'd2, MASK = 3'd3, SAMP = 3'd4;
  localparam logic [31:0] B18 = 32'h0004_0000, B19 = 32'h0008_0000;

  ir_sampler_top dut (.*);

  always #5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    hist[(cyc + 1) % 4096] <= ir_i;
  end

  initial forever begin
    @(negedge clk_i);
    ir_i = 1'($urandom);
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, output int e);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    e = cyc + 1;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic wait_until(input int t);
    if (cyc > t) begin
      n_chk++; n_fail++;
      $display("FAIL timing: cycle %0d past target %0d", cyc, t);
    end
    while (cyc < t) @(negedge clk_i);
  endtask

  // sample k (1-based) is the pin at edge e + k*p - 2; newest lands in bit 31
  function automatic logic [31:0] exp_word(input int e, input int p, input int w);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = hist[(e + (w * 32 + i + 1) * p - 2) % 4096];
    return r;
  endfunction

  task automatic start(input int d, input logic [31:0] m, output int e);
    int t;
    wr(CTRL, 32'd0, t);
    wr(STAT, B18 | B19, t);
    wr(DIV, 32'(d), t);
    wr(MASK, m, t);
    wr(CTRL, 32'd1, e);
  endtask

  initial begin
    logic [31:0] v, w0;
    int e, e2, p, t, d;
    logic mb;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk("R1 reg reset", v, 32'd0);
    end
    chk("R1 irq reset", 32'(irq_o), 32'd0);

    // R2 R3 R4 R5 R6 R8 random divider and mask
    for (int it = 0; it < 5; it++) begin
      d = (it == 0) ? 0 : $urandom_range(1, 12);
      mb = 1'($urandom);
      start(d, mb ? B18 : 32'd0, e);
      p = d + 1;
      wait_until(e + 32 * p - 1);
      rd(STAT, v);
      chk("R2 no status one edge early", v, 32'd0);
      wait_until(e + 32 * p);
      rd(SAMP, v);
      w0 = exp_word(e, p, 0);
      chk("R2/R3/R4 sample word", v, w0);
      rd(STAT, v);
      chk("R6 status set", v, B18);
      chk("R8 irq follows mask", 32'(irq_o), 32'(mb));
      wait_until(e + 48 * p);
      rd(SAMP, v);
      chk("R5 hold stable mid word", v, w0);
    end

    // R7 R10 overrun and back-to-back words
    start(2, B19, e);
    p = 3;
    wait_until(e + 64 * p);
    rd(SAMP, v);
    chk("R10 second word", v, exp_word(e, p, 1));
    rd(STAT, v);
    chk("R7 overrun set", v, B18 | B19);
    chk("R8 irq from overrun", 32'(irq_o), 32'd1);
    wr(CTRL, 32'd0, t);
    wr(STAT, 32'd0, t);
    rd(STAT, v);
    chk("R6 write zero ignored", v, B18 | B19);
    wr(STAT, B19, t);
    rd(STAT, v);
    chk("R7 overrun w1c", v, B18);
    chk("R8 irq drops with overrun", 32'(irq_o), 32'd0);
    wr(STAT, B18, t);
    rd(STAT, v);
    chk("R6 done w1c", v, 32'd0);

    // R6 set wins over same-edge clear
    start(1, 32'd0, e);
    p = 2;
    wait_until(e + 64 * p - 1);
    wr(STAT, B18, t);
    rd(STAT, v);
    chk("R6 set beats clear", v, B18);

    // R9 disable freezes state and restarts the count
    start(0, 32'd0, e);
    repeat (10) @(negedge clk_i);
    wr(CTRL, 32'd0, t);
    rd(SAMP, w0);
    repeat (100) @(negedge clk_i);
    rd(STAT, v);
    chk("R9 no status while off", v, 32'd0);
    rd(SAMP, v);
    chk("R9 sample frozen while off", v, w0);
    wr(CTRL, 32'd1, e2);
    wait_until(e2 + 31);
    rd(STAT, v);
    chk("R9 partial count discarded", v, 32'd0);
    wait_until(e2 + 32);
    rd(SAMP, v);
    chk("R9 fresh word after re-enable", v, exp_word(e2, 1, 0));

    if (!done_flag) begin
      done_flag = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!done_flag) begin
      done_flag = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not end");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule